// File: doc/BRIEF.md
# Host Adapter Command Port Controller

This block is the register front end that a host driver sees on a mailbox-based storage host adapter. It sits behind three byte-wide I/O offsets. Offset 0 is a write-only control register and a read-only status register. Offset 1 is a write-only command/parameter port and a read-only data-in port. Offset 2 is a read-only interrupt register.

The host writes an opcode byte to offset 1, then any parameter bytes, and then reads any reply bytes from offset 1. The status busy and data-ready bits pace each byte. When a command finishes, a latched command-complete bit is set in the interrupt register. The host clears it by writing the interrupt-reset bit to the control register.

A small opcode table supplies the parameter count, the reply length and the fixed reply bytes. The start-mailbox opcode gives a one-cycle pulse to the mailbox scanning engine, which lies outside this block. The mailbox count and base address written by the initialise command are presented to that engine. The engine reports back through two strobes that latch interrupt bits.

Top module: `hostCmdPort`

## Requirements
- R1: After reset release or a control write with bit 0x80 (hard reset), status reads exactly 0x80 (diagnostic active) for DIAG_CYCLES cycles. It then reads exactly 0x30 (initialisation required 0x20 plus adapter ready 0x10). The interrupt register reads 0x00, and the mailbox count and base read zero.
- R2: Each byte accepted at offset 1 sets status bit 0x08 (busy) for exactly BUSY_CYCLES cycles. An offset-1 write made while busy, or during the diagnostic period, is dropped.
- R3: Status bit 0x10 (adapter ready) is set only when no command is in progress, busy is clear and no diagnostic is running. Status bit 0x40 always reads 0.
- R4: Opcode 0x04 takes no parameters and replies 0x41, 0x30, 0x33, 0x32. Status bit 0x04 (data-in ready) sets one cycle after the reply phase begins, and again one cycle after each read. Reading offset 1 clears it. The read of the last byte sets command complete.
- R5: Opcode 0x0B takes no parameters and replies 0x00, 0x04, 0x07.
- R6: Opcode 0x01 takes 4 parameters: the mailbox count, then a 24-bit base address, most significant byte first. When it completes, the count and base appear on the outputs, status bit 0x20 clears and command complete sets.
- R7: Opcode 0x8D takes 1 parameter N and replies with N bytes. The first byte is 0x45 ('E') and the rest are 0x00. When N = 0, the command completes at once.
- R8: Opcode 0x02 gives a one-cycle pulse on mboxStart and never sets command complete. It is accepted when idle, and also while a reply is pending (adapter ready clear).
- R9: Any other opcode sets status bit 0x01 (command invalid) and command complete. All further offset-1 bytes are then discarded until an interrupt-reset write.
- R10: Interrupt bits are 0x01 (incoming mailbox loaded, from mbxInLoaded), 0x02 (outgoing mailbox free, from mbxOutFree), 0x04 (command complete) and 0x08 (bus reset state, set by control bit 0x10). Bit 0x80 reads 1 whenever any of these is set, and irqOut follows it.
- R11: Control bit 0x20 clears all interrupt bits and command invalid. A set that arrives in the same cycle wins. Control bit 0x40 (soft reset) returns the sequencer to idle and clears data-in ready and command invalid. It keeps the interrupt bits and initialisation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, same effect as hard reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect at offset 1 only) |
| regAddr | input | 2 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt request, the interrupt-valid bit |
| mboxStart | output | 1 | One-cycle pulse on start-mailbox opcode |
| mboxCount | output | 8 | Mailbox count from initialise command |
| mboxBase | output | 24 | Mailbox base address from initialise command |
| mbxInLoaded | input | 1 | Mailbox engine strobe: incoming mailbox loaded |
| mbxOutFree | input | 1 | Mailbox engine strobe: outgoing mailbox free |

## Verification
The assertions assume that at most one register access occurs per cycle. As a result, a control write never coincides with an offset-1 transfer. They also assume BUSY_CYCLES is at least one, which keeps two start pulses from landing back to back. The stimulus tasks drive exactly one strobe per access and leave idle cycles between accesses. The behavioural model predicts dropped writes from its own busy count, so back-to-back offset-1 writes stay legal stimulus.

// File: rtl/hcpPkg.sv
package hcpPkg;

  localparam logic [7:0] OP_INIT_MBX = 8'h01;
  localparam logic [7:0] OP_START    = 8'h02;
  localparam logic [7:0] OP_INQ      = 8'h04;
  localparam logic [7:0] OP_CFG      = 8'h0B;
  localparam logic [7:0] OP_EXT      = 8'h8D;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_PARAM   = 2'd1,
    SEQ_REPLY   = 2'd2,
    SEQ_DISCARD = 2'd3
  } seqState_t;

  typedef struct packed {
    logic       hardRst;
    logic       softRst;
    logic       intClr;
    logic       busRst;
    logic       clrDir;
    logic       loadReply;
    logic [7:0] replyByte;
    logic       setCmdc;
    logic       setInv;
    logic       initDone;
    logic       mbxParamWr;
    logic [1:0] paramIdx;
    logic [7:0] paramByte;
    logic       mboxGo;
  } hcpStrobe_t;

  function automatic logic isKnown(input logic [7:0] op);
    return (op == OP_INIT_MBX) || (op == OP_START) || (op == OP_INQ) ||
           (op == OP_CFG) || (op == OP_EXT);
  endfunction

  function automatic logic [2:0] paramCount(input logic [7:0] op);
    case (op)
      OP_INIT_MBX: return 3'd4;
      OP_EXT:      return 3'd1;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] fixedReplyLen(input logic [7:0] op);
    case (op)
      OP_INQ:  return 8'd4;
      OP_CFG:  return 8'd3;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] replyData(input logic [7:0] op, input logic [7:0] idx);
    case (op)
      OP_INQ: begin
        case (idx[1:0])
          2'd0:    return 8'h41;
          2'd1:    return 8'h30;
          2'd2:    return 8'h33;
          default: return 8'h32;
        endcase
      end
      OP_CFG: begin
        case (idx[1:0])
          2'd0:    return 8'h00;
          2'd1:    return 8'h04;
          default: return 8'h07;
        endcase
      end
      OP_EXT:  return (idx == 8'd0) ? 8'h45 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hcpCtrl.sv
module hcpCtrl
  import hcpPkg::*;
#(
  parameter int BUSY_CYCLES = 2,
  parameter int DIAG_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       dirRdy,
  output hcpStrobe_t strobe,
  output logic       diagActive,
  output logic       cprBusy,
  output logic       seqIdle
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam int DW = $clog2(DIAG_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);
  localparam logic [DW-1:0] DIAG_LOAD = DW'(DIAG_CYCLES);

  seqState_t      state;
  logic [7:0]     curOp;
  logic [2:0]     pIdx;
  logic [7:0]     rLen;
  logic [7:0]     rIdx;
  logic [BW-1:0]  busyCnt;
  logic [DW-1:0]  diagCnt;

  logic ctlWr, cprWr, dinRd, lastRead, lastParam;

  assign diagActive = (diagCnt != '0);
  assign cprBusy    = (busyCnt != '0);
  assign seqIdle    = (state == SEQ_IDLE);

  assign ctlWr     = regWrEn && (regAddr == 2'd0);
  assign cprWr     = regWrEn && (regAddr == 2'd1) && !cprBusy && !diagActive;
  assign dinRd     = regRdEn && (regAddr == 2'd1) && dirRdy;
  assign lastRead  = dinRd && (state == SEQ_REPLY) && (8'(rIdx + 8'd1) == rLen);
  assign lastParam = (3'(pIdx + 3'd1) == paramCount(curOp));

  always_comb begin
    strobe           = '0;
    strobe.hardRst   = ctlWr && regWrData[7];
    strobe.softRst   = ctlWr && regWrData[6] && !regWrData[7];
    strobe.intClr    = ctlWr && regWrData[5];
    strobe.busRst    = ctlWr && regWrData[4];
    strobe.clrDir    = dinRd;
    strobe.loadReply = (state == SEQ_REPLY) && !dirRdy;
    strobe.replyByte = replyData(curOp, rIdx);
    strobe.paramIdx  = pIdx[1:0];
    strobe.paramByte = regWrData;
    if (lastRead) strobe.setCmdc = 1'b1;
    if (cprWr) begin
      case (state)
        SEQ_IDLE: begin
          if (regWrData == OP_START) strobe.mboxGo = 1'b1;
          else if (!isKnown(regWrData)) begin
            strobe.setInv  = 1'b1;
            strobe.setCmdc = 1'b1;
          end
        end
        SEQ_PARAM: begin
          if (curOp == OP_INIT_MBX) begin
            strobe.mbxParamWr = 1'b1;
            if (lastParam) begin
              strobe.initDone = 1'b1;
              strobe.setCmdc  = 1'b1;
            end
          end else if (curOp == OP_EXT && regWrData == 8'd0) begin
            strobe.setCmdc = 1'b1;
          end
        end
        SEQ_REPLY: if (regWrData == OP_START) strobe.mboxGo = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      curOp   <= '0;
      pIdx    <= '0;
      rLen    <= '0;
      rIdx    <= '0;
      busyCnt <= '0;
      diagCnt <= DIAG_LOAD;
    end else begin
      diagCnt <= strobe.hardRst ? DIAG_LOAD : (diagActive ? diagCnt - 1'b1 : '0);
      if (strobe.hardRst || strobe.softRst) busyCnt <= '0;
      else if (cprWr)                       busyCnt <= BUSY_LOAD;
      else if (cprBusy)                     busyCnt <= busyCnt - 1'b1;

      if (strobe.hardRst || strobe.softRst) begin
        state <= SEQ_IDLE;
      end else begin
        if (state == SEQ_DISCARD && strobe.intClr) state <= SEQ_IDLE;
        if (dinRd && state == SEQ_REPLY) begin
          rIdx <= 8'(rIdx + 8'd1);
          if (lastRead) state <= SEQ_IDLE;
        end
        if (cprWr) begin
          case (state)
            SEQ_IDLE: begin
              curOp <= regWrData;
              pIdx  <= '0;
              rIdx  <= '0;
              if (!isKnown(regWrData)) state <= SEQ_DISCARD;
              else if (paramCount(regWrData) != 3'd0) state <= SEQ_PARAM;
              else if (fixedReplyLen(regWrData) != 8'd0) begin
                rLen  <= fixedReplyLen(regWrData);
                state <= SEQ_REPLY;
              end
            end
            SEQ_PARAM: begin
              pIdx <= 3'(pIdx + 3'd1);
              if (curOp == OP_EXT) begin
                rLen  <= regWrData;
                state <= (regWrData == 8'd0) ? SEQ_IDLE : SEQ_REPLY;
              end else if (lastParam) begin
                state <= SEQ_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R2: an accepted byte raises busy on the next cycle
  p_write_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    cprWr |=> cprBusy);

  // R1: no command runs during the diagnostic period
  p_diag_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    diagActive |-> (state == SEQ_IDLE));

  // R9: bytes written after an invalid opcode keep the sequencer discarding
  p_discard_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_DISCARD && cprWr) |=> (state == SEQ_DISCARD));

endmodule

// File: rtl/hcpData.sv
module hcpData
  import hcpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  hcpStrobe_t  strobe,
  input  logic        diagActive,
  input  logic        cprBusy,
  input  logic        seqIdle,
  input  logic        mbxInLoaded,
  input  logic        mbxOutFree,
  output logic [7:0]  regRdData,
  output logic        dirRdy,
  output logic        irqOut,
  output logic        mboxStart,
  output logic [7:0]  mboxCount,
  output logic [23:0] mboxBase
);

  logic [7:0] dataIn;
  logic       cmdInv;
  logic       initReq;
  logic [3:0] intBits;
  logic [7:0] statusByte;
  logic [7:0] intByte;
  logic [3:0] intSet;

  assign statusByte = diagActive ? 8'h80 :
                      {2'b00, initReq, seqIdle && !cprBusy, cprBusy, dirRdy, 1'b0, cmdInv};
  assign intByte    = {|intBits, 3'b000, intBits};
  assign irqOut     = |intBits;
  assign intSet     = {strobe.busRst, strobe.setCmdc, mbxOutFree, mbxInLoaded};

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = statusByte;
      2'd1:    regRdData = dataIn;
      2'd2:    regRdData = intByte;
      default: regRdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataIn    <= '0;
      dirRdy    <= 1'b0;
      cmdInv    <= 1'b0;
      initReq   <= 1'b1;
      intBits   <= '0;
      mboxStart <= 1'b0;
      mboxCount <= '0;
      mboxBase  <= '0;
    end else begin
      mboxStart <= strobe.mboxGo;
      if (strobe.loadReply) dataIn <= strobe.replyByte;

      if (strobe.hardRst || strobe.softRst) dirRdy <= 1'b0;
      else if (strobe.loadReply)            dirRdy <= 1'b1;
      else if (strobe.clrDir)               dirRdy <= 1'b0;

      if (strobe.setInv) cmdInv <= 1'b1;
      else if (strobe.hardRst || strobe.softRst || strobe.intClr) cmdInv <= 1'b0;

      if (strobe.hardRst)       initReq <= 1'b1;
      else if (strobe.initDone) initReq <= 1'b0;

      intBits <= ((strobe.hardRst || strobe.intClr) ? 4'b0000 : intBits) | intSet;

      if (strobe.hardRst) begin
        mboxCount <= '0;
        mboxBase  <= '0;
      end else if (strobe.mbxParamWr) begin
        case (strobe.paramIdx)
          2'd0:    mboxCount       <= strobe.paramByte;
          2'd1:    mboxBase[23:16] <= strobe.paramByte;
          2'd2:    mboxBase[15:8]  <= strobe.paramByte;
          default: mboxBase[7:0]   <= strobe.paramByte;
        endcase
      end
    end
  end

  // R4: reading the data-in port empties it
  p_dir_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDir |=> !dirRdy);

  // R6: completion of mailbox initialisation clears the init-required flag
  p_init_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initDone |=> !initReq);

  // R9: an invalid opcode raises both invalid status and command complete
  p_inv_cmdc_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setInv |=> (cmdInv && intBits[2]));

  // R11: interrupt reset with no competing set leaves nothing latched
  p_int_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.intClr && !strobe.busRst && !strobe.setCmdc && !mbxInLoaded && !mbxOutFree)
      |=> (intBits == 4'b0000));

  // R8: the start pulse lasts one cycle
  p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    mboxStart |=> !mboxStart);

endmodule

// File: rtl/hostCmdPort.sv
module hostCmdPort
  import hcpPkg::*;
#(
  parameter int BUSY_CYCLES = 2,
  parameter int DIAG_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  output logic        irqOut,
  output logic        mboxStart,
  output logic [7:0]  mboxCount,
  output logic [23:0] mboxBase,
  input  logic        mbxInLoaded,
  input  logic        mbxOutFree
);

  hcpStrobe_t strobe;
  logic       diagActive, cprBusy, seqIdle, dirRdy;

  hcpCtrl #(.BUSY_CYCLES(BUSY_CYCLES), .DIAG_CYCLES(DIAG_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .dirRdy(dirRdy),
    .strobe(strobe), .diagActive(diagActive), .cprBusy(cprBusy), .seqIdle(seqIdle)
  );

  hcpData i_data (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .strobe(strobe),
    .diagActive(diagActive), .cprBusy(cprBusy), .seqIdle(seqIdle),
    .mbxInLoaded(mbxInLoaded), .mbxOutFree(mbxOutFree),
    .regRdData(regRdData), .dirRdy(dirRdy), .irqOut(irqOut),
    .mboxStart(mboxStart), .mboxCount(mboxCount), .mboxBase(mboxBase)
  );

endmodule

// File: tb/test_hostCmdPort.sv
`timescale 1ns/1ps
module test_hostCmdPort;

  localparam int BUSY = 2;
  localparam int DIAG = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        irqOut, mboxStart;
  logic [7:0]  mboxCount;
  logic [23:0] mboxBase;
  logic        mbxInLoaded = 1'b0, mbxOutFree = 1'b0;

  int checks = 0, fails = 0, pulses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hostCmdPort #(.BUSY_CYCLES(BUSY), .DIAG_CYCLES(DIAG)) i_hostCmdPort (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .mboxStart(mboxStart), .mboxCount(mboxCount),
    .mboxBase(mboxBase), .mbxInLoaded(mbxInLoaded), .mbxOutFree(mbxOutFree)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         mState;   // 0 idle, 1 params, 2 reply, 3 discard
  int         mBusy, mDiag, mPidx;
  bit         mDir, mInv, mInit, mStart;
  logic [3:0] mInts;
  logic [7:0] mOp, mDataIn, mCount;
  logic [23:0] mBase;
  logic [7:0] mQ[$];

  always @(posedge clk) begin
    bit ctl, acc, rd, load;
    logic [3:0] setBits;
    if (!rstN) begin
      mState = 0; mBusy = 0; mDiag = DIAG; mPidx = 0; mDir = 0; mInv = 0; mInit = 1;
      mStart = 0; mInts = 0; mOp = 0; mDataIn = 0; mCount = 0; mBase = 0; mQ.delete();
    end else begin
      ctl  = regWrEn && regAddr == 2'd0;
      acc  = regWrEn && regAddr == 2'd1 && mBusy == 0 && mDiag == 0;
      rd   = regRdEn && regAddr == 2'd1 && mDir;
      load = (mState == 2) && !mDir;
      setBits = {ctl && regWrData[4], 1'b0, mbxOutFree, mbxInLoaded};
      mStart = 0;
      if (mDiag > 0) mDiag--;
      if (mBusy > 0) mBusy--;
      if (ctl && regWrData[7]) begin
        mState = 0; mDiag = DIAG; mBusy = 0; mDir = 0; mInv = 0; mInit = 1;
        mInts = 0; mCount = 0; mBase = 0; mQ.delete();
      end else if (ctl && regWrData[6]) begin
        mState = 0; mBusy = 0; mDir = 0; mInv = 0; mQ.delete();
        if (regWrData[5]) mInts = 0;
      end else begin
        if (ctl && regWrData[5]) begin
          mInts = 0; mInv = 0;
          if (mState == 3) mState = 0;
        end
        if (load) begin
          mDataIn = mQ.pop_front(); mDir = 1;
        end else if (rd) begin
          mDir = 0;
          if (mQ.size() == 0) begin mInts[2] = 1; mState = 0; end
        end
        if (acc) begin
          mBusy = BUSY;
          case (mState)
            0: begin
              mOp = regWrData; mPidx = 0;
              case (regWrData)
                8'h02: mStart = 1;
                8'h01, 8'h8D: mState = 1;
                8'h04: begin mQ = '{8'h41, 8'h30, 8'h33, 8'h32}; mState = 2; end
                8'h0B: begin mQ = '{8'h00, 8'h04, 8'h07}; mState = 2; end
                default: begin mInv = 1; mInts[2] = 1; mState = 3; end
              endcase
            end
            1: begin
              if (mOp == 8'h01) begin
                case (mPidx)
                  0: mCount = regWrData;
                  1: mBase[23:16] = regWrData;
                  2: mBase[15:8] = regWrData;
                  default: mBase[7:0] = regWrData;
                endcase
                mPidx++;
                if (mPidx == 4) begin mInit = 0; mInts[2] = 1; mState = 0; end
              end else begin
                if (regWrData == 0) begin mInts[2] = 1; mState = 0; end
                else begin
                  mQ.push_back(8'h45);
                  for (int i = 1; i < regWrData; i++) mQ.push_back(8'h00);
                  mState = 2;
                end
              end
            end
            2: if (regWrData == 8'h02) mStart = 1;
            default: ;
          endcase
        end
      end
      mInts = mInts | setBits;
    end
  end

  always @(posedge clk) if (rstN && mboxStart) pulses++;

  // compare the design against the model every cycle, before the edge
  always @(negedge clk) begin
    logic [7:0] expRd;
    #3;
    if (rstN && !finished) begin
      case (regAddr)
        2'd0: expRd = (mDiag > 0) ? 8'h80 :
                      {2'b00, mInit, (mState == 0 && mBusy == 0), (mBusy > 0), mDir, 1'b0, mInv};
        2'd1: expRd = mDataIn;
        2'd2: expRd = {|mInts, 3'b000, mInts};
        default: expRd = 8'h00;
      endcase
      check(regAddr == 2'd1 ? "R4 model data-in" : (regAddr == 2'd2 ? "R10 model int" : "R3 model status"),
            {24'd0, regRdData}, {24'd0, expRd});
      check("R10 model irq", {31'd0, irqOut}, {31'd0, |mInts});
      check("R8 model start pulse", {31'd0, mboxStart}, {31'd0, mStart});
      check("R6 model mailbox config", {mboxCount, mboxBase}, {mCount, mBase});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #3 v = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic getReply(output logic [7:0] v);
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      rdReg(2'd0, s);
      if (s[2]) break;
    end
    rdReg(2'd1, v);
  endtask

  task automatic pulseIn(input bit outSide);
    @(negedge clk);
    if (outSide) mbxOutFree = 1'b1; else mbxInLoaded = 1'b1;
    @(posedge clk); #1;
    mbxOutFree = 1'b0; mbxInLoaded = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p0;
    idle(4);
    @(negedge clk) rstN = 1'b1;
    // R1: diagnostic then idle with init required
    rdReg(2'd0, v); check("R1 diag status", {24'd0, v}, 32'h80);
    idle(DIAG + 2);
    rdReg(2'd0, v); check("R1 status after reset", {24'd0, v}, 32'h30);
    rdReg(2'd2, v); check("R1 int after reset", {24'd0, v}, 32'h00);

    // R6: initialise mailbox
    wrReg(2'd1, 8'h01); idle(BUSY);
    wrReg(2'd1, 8'h10); idle(BUSY);
    wrReg(2'd1, 8'h12); idle(BUSY);
    wrReg(2'd1, 8'h34); idle(BUSY);
    wrReg(2'd1, 8'h56); idle(BUSY);
    check("R6 count", {24'd0, mboxCount}, 32'h10);
    check("R6 base", {8'd0, mboxBase}, 32'h123456);
    rdReg(2'd0, v); check("R6 init cleared", {24'd0, v}, 32'h10);
    rdReg(2'd2, v); check("R6 cmdc", {24'd0, v}, 32'h84);
    check("R10 irq high", {31'd0, irqOut}, 32'd1);
    wrReg(2'd0, 8'h20);
    rdReg(2'd2, v); check("R11 int clear", {24'd0, v}, 32'h00);

    // R4 / R2: adapter inquiry
    wrReg(2'd1, 8'h04);
    rdReg(2'd0, v); check("R2 busy while reply pending", {24'd0, v}, 32'h08);
    getReply(v); check("R4 byte0", {24'd0, v}, 32'h41);
    rdReg(2'd0, v); check("R4 dir cleared by read", {24'd0, v & 8'h04}, 32'h00);
    getReply(v); check("R4 byte1", {24'd0, v}, 32'h30);
    getReply(v); check("R4 byte2", {24'd0, v}, 32'h33);
    rdReg(2'd2, v); check("R4 no cmdc before last", {24'd0, v}, 32'h00);
    getReply(v); check("R4 byte3", {24'd0, v}, 32'h32);
    rdReg(2'd2, v); check("R4 cmdc after last", {24'd0, v}, 32'h84);
    wrReg(2'd0, 8'h20);

    // R5: inquire configuration
    wrReg(2'd1, 8'h0B);
    getReply(v); check("R5 byte0", {24'd0, v}, 32'h00);
    getReply(v); check("R5 byte1", {24'd0, v}, 32'h04);
    getReply(v); check("R5 byte2", {24'd0, v}, 32'h07);
    rdReg(2'd0, v); check("R5 idle again", {24'd0, v}, 32'h10);
    wrReg(2'd0, 8'h20);

    // R7: extended setup, N=3 and N=0
    wrReg(2'd1, 8'h8D); idle(BUSY);
    wrReg(2'd1, 8'h03);
    getReply(v); check("R7 first E", {24'd0, v}, 32'h45);
    getReply(v); check("R7 byte1", {24'd0, v}, 32'h00);
    getReply(v); check("R7 byte2", {24'd0, v}, 32'h00);
    rdReg(2'd2, v); check("R7 cmdc", {24'd0, v}, 32'h84);
    wrReg(2'd0, 8'h20);
    wrReg(2'd1, 8'h8D); idle(BUSY);
    wrReg(2'd1, 8'h00);
    rdReg(2'd2, v); check("R7 zero length completes", {24'd0, v}, 32'h84);
    idle(BUSY);
    rdReg(2'd0, v); check("R7 zero length idle", {24'd0, v}, 32'h10);
    wrReg(2'd0, 8'h20);

    // R8 / R2: start mailbox, back-to-back second write dropped
    p0 = pulses;
    wrReg(2'd1, 8'h02);
    wrReg(2'd1, 8'h02);
    idle(BUSY + 1);
    check("R2 dropped while busy", pulses - p0, 1);
    rdReg(2'd2, v); check("R8 no cmdc", {24'd0, v}, 32'h00);
    p0 = pulses;
    wrReg(2'd1, 8'h04); idle(BUSY);
    wrReg(2'd1, 8'h02); idle(BUSY);
    check("R8 start during reply", pulses - p0, 1);
    getReply(v); check("R8 reply intact", {24'd0, v}, 32'h41);
    getReply(v); getReply(v); getReply(v);
    check("R8 reply last", {24'd0, v}, 32'h32);
    wrReg(2'd0, 8'h20);

    // R9: invalid opcode and discard
    wrReg(2'd1, 8'h77);
    rdReg(2'd2, v); check("R9 cmdc on invalid", {24'd0, v}, 32'h84);
    idle(BUSY);
    wrReg(2'd1, 8'h04); idle(BUSY + 3);
    rdReg(2'd0, v); check("R9 discard keeps invalid, no data", {24'd0, v}, 32'h01);
    wrReg(2'd0, 8'h20);
    rdReg(2'd0, v); check("R11 invalid cleared", {24'd0, v}, 32'h10);
    wrReg(2'd1, 8'h04);
    getReply(v); check("R9 accepted after clear", {24'd0, v}, 32'h41);

    // R11: soft reset mid-reply keeps interrupts
    pulseIn(1'b0);
    wrReg(2'd0, 8'h40);
    rdReg(2'd0, v); check("R11 soft reset status", {24'd0, v}, 32'h10);
    rdReg(2'd2, v); check("R11 soft keeps int", {24'd0, v}, 32'h81);

    // R10: interrupt sources
    pulseIn(1'b1);
    rdReg(2'd2, v); check("R10 out free", {24'd0, v}, 32'h83);
    wrReg(2'd0, 8'h10);
    rdReg(2'd2, v); check("R10 bus reset bit", {24'd0, v}, 32'h8B);
    wrReg(2'd0, 8'h30);
    rdReg(2'd2, v); check("R11 set wins over clear", {24'd0, v}, 32'h88);
    wrReg(2'd0, 8'h20);
    check("R10 irq low", {31'd0, irqOut}, 32'd0);

    // R1: hard reset
    wrReg(2'd0, 8'h80);
    rdReg(2'd0, v); check("R1 hard reset diag", {24'd0, v}, 32'h80);
    wrReg(2'd1, 8'h04);
    idle(DIAG + 2);
    rdReg(2'd0, v); check("R1 hard reset idle", {24'd0, v}, 32'h30);
    check("R1 config cleared", {mboxCount, mboxBase}, 32'd0);
    rdReg(2'd0, v); check("R3 ready only when idle", {24'd0, v & 8'h50}, 32'h10);

    idle(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule